// File: doc/BRIEF.md
# Three-Mode 16-bit Timer/Counter

This block is a 16-bit down-counter with two 16-bit auxiliary registers, called A and B. A three-bit mode field chooses one of three uses for them.

- **Waveform mode.** The counter runs on the clock. Each time it underflows it reloads from A and B in turn and toggles a square-wave output. Software sets the high and low times by writing A and B, and the processor does no further work.
- **Event mode.** The counter steps down once for each chosen edge on pin A. When it underflows it reloads from A and raises a pending flag.
- **Capture mode.** The counter runs down freely. An edge on pin A or pin B copies the counter value into register A or register B.

Both pins pass through a two-flop synchronizer before edge detection. Outside capture mode, pin B serves as a separate rising-edge interrupt input when its enable is set.

Control is a finite-state machine with five states:

- `ST_HALT`: the counter is frozen.
- `ST_PWM_A`: waveform mode; the next reload comes from B.
- `ST_PWM_B`: waveform mode; the next reload comes from A.
- `ST_EVENT`: event mode.
- `ST_CAPTURE`: capture mode.

The transitions are:

- **Mode decode.** On every clock, a change of the mode field moves the machine to the state for the new mode. Entering waveform mode always lands in `ST_PWM_A`.
- **Phase flip.** An underflow in `ST_PWM_A` moves the machine to `ST_PWM_B`, and an underflow in `ST_PWM_B` moves it back to `ST_PWM_A`.

Software writes the counter, A and B through a simple strobe-and-select port. It reads all three on dedicated outputs.

Top module: `tri_mode_timer`

## Requirements
- R1: After reset the counter, registers A and B, both pending flags and the waveform output are 0, and the state is halt.
- R2: With `wr_en` high, `wr_sel` 0 loads the counter, 1 loads register A and 2 loads register B from `wr_data` at the next clock. A write takes priority over any hardware update of the same register in that cycle.
- R3: In waveform mode with `run` high, the counter decrements each clock. When the counter is 0 it reloads instead of decrementing, from B on the first underflow after entering the mode and then alternately from A and B. Each underflow toggles `pwm_out` and sets `pend_a`.
- R4: In waveform and event modes, `run` low freezes the counter and `pwm_out`.
- R5: In event mode with `run` high, the counter decrements once per selected edge of pin A. `edge_pos` 1 selects rising edges and 0 selects falling edges. At 0 the counter reloads from register A and sets `pend_a`.
- R6: In capture mode the counter decrements every clock whatever `run` is, and wraps from 0 to 16'hFFFF.
- R7: In capture mode a selected edge (polarity as in R5) on pin A copies the counter into register A and sets `pend_a`. A selected edge on pin B does the same into register B and sets `pend_b`.
- R8: Outside capture mode, a rising edge on pin B sets `pend_b` only while `b_int_en` is 1; with `b_int_en` 0 it has no effect.
- R9: Pending flags stay set until `clr_a`/`clr_b` clears them. A set in the same cycle as a clear wins.
- R10: A pin change made before clock edge k is acted on at clock edge k+2 and is visible on the outputs after that edge.
- R11: `mode_sel` encodes 3'b001 waveform, 3'b010 event and 3'b100 capture; any other value halts the counter. A new mode takes effect from the clock edge after the one that samples it.
- R12: `pwm_out` is driven to 0 one clock after the state leaves waveform mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode field (R11) |
| run | input | 1 | Start/stop for waveform and event modes |
| edge_pos | input | 1 | 1 = rising, 0 = falling edges for event and capture |
| b_int_en | input | 1 | Enables pin B as an interrupt outside capture mode |
| pin_a | input | 1 | Timer pin A (asynchronous) |
| pin_b | input | 1 | Timer pin B (asynchronous) |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 A, 2 B |
| wr_data | input | 16 | Write data |
| clr_a | input | 1 | Clears `pend_a` |
| clr_b | input | 1 | Clears `pend_b` |
| cnt_q | output | 16 | Counter value |
| reg_a_q | output | 16 | Register A |
| reg_b_q | output | 16 | Register B |
| pend_a | output | 1 | Underflow / capture A pending |
| pend_b | output | 1 | Capture B / pin B interrupt pending |
| pwm_out | output | 1 | Waveform output |

## Verification
The bench targets the reload at zero and the B-then-A order of reloads. A design that decremented past zero, or reloaded from the wrong register, would produce a waveform whose phases are off by one clock or swapped. It probes the three-edge pin latency and the edge polarity switch, which a design with a missing synchronizer stage or an inverted polarity select would get wrong by a cycle or by an edge. It also covers the capture wrap through zero, and the rule that a set beats a clear, which a design giving the clear priority would lose as a dropped interrupt. Finally it checks that the pin B interrupt obeys its enable, so a design ignoring the enable would raise spurious flags.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [2:0] MODE_PWM = 3'b001;
    localparam logic [2:0] MODE_EVT = 3'b010;
    localparam logic [2:0] MODE_CAP = 3'b100;

    localparam logic [1:0] SEL_CNT = 2'd0;
    localparam logic [1:0] SEL_A   = 2'd1;
    localparam logic [1:0] SEL_B   = 2'd2;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_PWM_A,
        ST_PWM_B,
        ST_EVENT,
        ST_CAPTURE
    } tmr_state_e;
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;
    logic         last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[TOP-1:0], pin};
            last  <= chain[TOP];
        end
    end

    assign rise = chain[TOP] & ~last;
    assign fall = ~chain[TOP] & last;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode_sel,
    input  logic         run,
    input  logic         edge_pos,
    input  logic         b_int_en,
    input  logic         rise_a,
    input  logic         fall_a,
    input  logic         rise_b,
    input  logic         fall_b,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         clr_a,
    input  logic         clr_b,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] reg_a_q,
    output logic [W-1:0] reg_b_q,
    output logic         pend_a,
    output logic         pend_b,
    output logic         pwm_out,
    output tmr_state_e   st_q
);
    tmr_state_e st_nxt;
    logic       sel_a, sel_b, is_pwm, tick, uflow;
    logic       wr_cnt, wr_a, wr_b;

    function automatic tmr_state_e mode_state(input logic [2:0] m);
        case (m)
            MODE_PWM: mode_state = ST_PWM_A;
            MODE_EVT: mode_state = ST_EVENT;
            MODE_CAP: mode_state = ST_CAPTURE;
            default:  mode_state = ST_HALT;
        endcase
    endfunction

    assign sel_a  = edge_pos ? rise_a : fall_a;
    assign sel_b  = edge_pos ? rise_b : fall_b;
    assign is_pwm = (st_q == ST_PWM_A) || (st_q == ST_PWM_B);
    assign wr_cnt = wr_en && (wr_sel == SEL_CNT);
    assign wr_a   = wr_en && (wr_sel == SEL_A);
    assign wr_b   = wr_en && (wr_sel == SEL_B);

    always_comb begin
        tick = 1'b0;
        unique case (st_q)
            ST_HALT:            tick = 1'b0;
            ST_PWM_A, ST_PWM_B: tick = run;
            ST_EVENT:           tick = run & sel_a;
            ST_CAPTURE:         tick = 1'b1;
        endcase
    end

    assign uflow = tick && (cnt_q == '0) && (st_q != ST_CAPTURE);

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_PWM_A: begin
                if (mode_sel != MODE_PWM) st_nxt = mode_state(mode_sel);
                else if (uflow)           st_nxt = ST_PWM_B;
            end
            ST_PWM_B: begin
                if (mode_sel != MODE_PWM) st_nxt = mode_state(mode_sel);
                else if (uflow)           st_nxt = ST_PWM_A;
            end
            ST_HALT, ST_EVENT, ST_CAPTURE: st_nxt = mode_state(mode_sel);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            reg_a_q <= '0;
            reg_b_q <= '0;
            pend_a  <= 1'b0;
            pend_b  <= 1'b0;
            pwm_out <= 1'b0;
        end else begin
            if (wr_cnt)      cnt_q <= wr_data;
            else if (uflow)  cnt_q <= (st_q == ST_PWM_A) ? reg_b_q : reg_a_q;
            else if (tick)   cnt_q <= cnt_q - 1'b1;

            if (wr_a)                                reg_a_q <= wr_data;
            else if (st_q == ST_CAPTURE && sel_a)    reg_a_q <= cnt_q;

            if (wr_b)                                reg_b_q <= wr_data;
            else if (st_q == ST_CAPTURE && sel_b)    reg_b_q <= cnt_q;

            pend_a <= uflow || (st_q == ST_CAPTURE && sel_a) || (pend_a && !clr_a);
            pend_b <= (st_q == ST_CAPTURE ? sel_b : (rise_b && b_int_en))
                      || (pend_b && !clr_b);

            if (is_pwm) begin
                if (uflow) pwm_out <= ~pwm_out;
            end else begin
                pwm_out <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tri_mode_timer.sv
module tri_mode_timer
    import tmr_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode_sel,
    input  logic         run,
    input  logic         edge_pos,
    input  logic         b_int_en,
    input  logic         pin_a,
    input  logic         pin_b,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         clr_a,
    input  logic         clr_b,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] reg_a_q,
    output logic [W-1:0] reg_b_q,
    output logic         pend_a,
    output logic         pend_b,
    output logic         pwm_out
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] pins, rise_v, fall_v;
    tmr_state_e       st_w;

    assign pins = {pin_b, pin_a};

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        tmr_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[i]),
            .rise (rise_v[i]),
            .fall (fall_v[i])
        );
    end

    tmr_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_sel(mode_sel),
        .run     (run),
        .edge_pos(edge_pos),
        .b_int_en(b_int_en),
        .rise_a  (rise_v[0]),
        .fall_a  (fall_v[0]),
        .rise_b  (rise_v[1]),
        .fall_b  (fall_v[1]),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .clr_a   (clr_a),
        .clr_b   (clr_b),
        .cnt_q   (cnt_q),
        .reg_a_q (reg_a_q),
        .reg_b_q (reg_b_q),
        .pend_a  (pend_a),
        .pend_b  (pend_b),
        .pwm_out (pwm_out),
        .st_q    (st_w)
    );
endmodule

// File: rtl/tri_mode_timer_chk.sv
module tri_mode_timer_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   mode_sel,
    input logic         run,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic         clr_a,
    input logic         clr_b,
    input logic [W-1:0] cnt_q,
    input logic         pend_a,
    input logic         pend_b,
    input logic         pwm_out,
    input tmr_state_e   st
);
    logic in_pwm, cnt_wr;
    assign in_pwm = (st == ST_PWM_A) || (st == ST_PWM_B);
    assign cnt_wr = wr_en && (wr_sel == SEL_CNT);

    p_pwm_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwm && run && cnt_q == '0) |=> (pwm_out != $past(pwm_out)));

    p_pwm_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PWM_A && run && cnt_q == '0 && mode_sel == MODE_PWM) |=> (st == ST_PWM_B));

    p_stopped_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwm && !run && !cnt_wr) |=> ($stable(cnt_q) && $stable(pwm_out)));

    p_capture_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE && !cnt_wr) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

    p_pend_a_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a && !clr_a) |=> pend_a);

    p_pend_b_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_b && !clr_b) |=> pend_b);

    p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && !cnt_wr) |=> $stable(cnt_q));

    p_pwm_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_pwm) |=> !pwm_out);
endmodule

bind tri_mode_timer tri_mode_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_sel(mode_sel),
    .run     (run),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .clr_a   (clr_a),
    .clr_b   (clr_b),
    .cnt_q   (cnt_q),
    .pend_a  (pend_a),
    .pend_b  (pend_b),
    .pwm_out (pwm_out),
    .st      (st_w)
);

// File: tb/sim_tri_mode_timer.sv
`timescale 1ns/1ps
module sim_tri_mode_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'b000;
    logic        run = 1'b0, edge_pos = 1'b1, b_int_en = 1'b0;
    logic        pin_a = 1'b0, pin_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = '0;
    logic        clr_a = 1'b0, clr_b = 1'b0;
    logic [15:0] cnt_q, reg_a_q, reg_b_q;
    logic        pend_a, pend_b, pwm_out;

    int tests = 0, fails = 0, cycles = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    tri_mode_timer u0 (.*);

    // behavioural reference model: 0 halt, 1 wave (next reload B), 2 wave (next reload A), 3 event, 4 capture
    int m_st, m_cnt, m_ra, m_rb, m_pa, m_pb, m_out;
    bit m_qa[$], m_qb[$];
    bit m_la, m_lb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_ra = 0; m_rb = 0; m_pa = 0; m_pb = 0; m_out = 0;
            m_qa = '{0, 0}; m_qb = '{0, 0}; m_la = 0; m_lb = 0;
        end else begin
            bit sa, sb, ra, rb, fa, fb, ea, eb, tick, uf;
            int n_cnt, n_ra, n_rb, n_st;
            sa = m_qa[0]; sb = m_qb[0];
            ra = sa && !m_la; fa = !sa && m_la;
            rb = sb && !m_lb; fb = !sb && m_lb;
            m_la = sa; m_lb = sb;
            void'(m_qa.pop_front()); m_qa.push_back(pin_a);
            void'(m_qb.pop_front()); m_qb.push_back(pin_b);
            ea = edge_pos ? ra : fa;
            eb = edge_pos ? rb : fb;
            tick = (m_st == 1 || m_st == 2) ? run :
                   (m_st == 3) ? (run && ea) : (m_st == 4);
            uf = tick && m_cnt == 0 && m_st != 4;
            n_cnt = m_cnt; n_ra = m_ra; n_rb = m_rb;
            if (uf) n_cnt = (m_st == 1) ? m_rb : m_ra;
            else if (tick) n_cnt = (m_cnt + 65535) % 65536;
            if (m_st == 4 && ea) n_ra = m_cnt;
            if (m_st == 4 && eb) n_rb = m_cnt;
            if (wr_en && wr_sel == 0) n_cnt = wr_data;
            if (wr_en && wr_sel == 1) n_ra = wr_data;
            if (wr_en && wr_sel == 2) n_rb = wr_data;
            m_pa = (uf || (m_st == 4 && ea)) ? 1 : (clr_a ? 0 : m_pa);
            m_pb = ((m_st == 4) ? eb : (rb && b_int_en)) ? 1 : (clr_b ? 0 : m_pb);
            if (m_st == 1 || m_st == 2) begin
                if (uf) m_out = 1 - m_out;
            end else m_out = 0;
            n_st = (mode_sel == 3'b001) ? 1 : (mode_sel == 3'b010) ? 3 :
                   (mode_sel == 3'b100) ? 4 : 0;
            if ((m_st == 1 || m_st == 2) && mode_sel == 3'b001)
                n_st = uf ? 3 - m_st : m_st;
            m_st = n_st; m_cnt = n_cnt; m_ra = n_ra; m_rb = n_rb;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            tests++;
            if (cnt_q !== 16'(m_cnt) || reg_a_q !== 16'(m_ra) || reg_b_q !== 16'(m_rb) ||
                pend_a !== m_pa[0] || pend_b !== m_pb[0] || pwm_out !== m_out[0]) begin
                fails++;
                $display("FAIL %s model: act cnt=%h a=%h b=%h pa=%b pb=%b out=%b exp cnt=%h a=%h b=%h pa=%0d pb=%0d out=%0d",
                         cur_req, cnt_q, reg_a_q, reg_b_q, pend_a, pend_b, pwm_out,
                         m_cnt, m_ra, m_rb, m_pa, m_pb, m_out);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000) begin
            tests++; fails++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic pulse_a();
        pin_a = 1'b1; step(4); pin_a = 1'b0; step(4);
    endtask

    task automatic pulse_b();
        pin_b = 1'b1; step(4); pin_b = 1'b0; step(4);
    endtask

    task automatic clear_both();
        clr_a = 1'b1; clr_b = 1'b1; step(1); clr_a = 1'b0; clr_b = 1'b0;
    endtask

    initial begin
        int toggles, held;
        step(3);
        rst_n = 1'b1;
        step(1);
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 cnt", cnt_q, 0); chk("R1 pend", {pend_a, pend_b}, 0); chk("R1 pwm", pwm_out, 0);

        // R2 writes, R11 halt hold
        cur_req = "R2";
        wr(2'd1, 16'd3); wr(2'd2, 16'd5); wr(2'd0, 16'd9);
        chk("R2 A", reg_a_q, 3); chk("R2 B", reg_b_q, 5); chk("R2 cnt", cnt_q, 9);
        cur_req = "R11";
        step(5);
        chk("R11 halt hold", cnt_q, 9);
        mode_sel = 3'b111; step(5);
        chk("R11 illegal code holds", cnt_q, 9);

        // R3 waveform
        cur_req = "R3";
        wr(2'd0, 16'd0);
        mode_sel = 3'b001; run = 1'b1;
        toggles = 0;
        for (int i = 0; i < 40; i++) begin
            logic prev;
            prev = pwm_out; step(1);
            if (pwm_out != prev) toggles++;
        end
        chk("R3 toggles", (toggles >= 6) ? 1 : 0, 1);
        chk("R3 pend_a on underflow", pend_a, 1);

        // R4 stop
        cur_req = "R4";
        run = 1'b0; step(1);
        held = cnt_q;
        step(10);
        chk("R4 frozen", cnt_q, held);

        // R12 leaving waveform mode
        cur_req = "R12";
        run = 1'b1;
        while (pwm_out != 1'b1) step(1);
        mode_sel = 3'b000; step(2);
        chk("R12 pwm low", pwm_out, 0);

        // R5 event mode, rising then falling
        cur_req = "R5";
        run = 1'b1; edge_pos = 1'b1; mode_sel = 3'b010;
        clear_both();
        wr(2'd1, 16'd7); wr(2'd0, 16'd2);
        pulse_a(); pulse_a();
        chk("R5 count", cnt_q, 0);
        pulse_a();
        chk("R5 reload", cnt_q, 7); chk("R5 pend", pend_a, 1);
        edge_pos = 1'b0; wr(2'd0, 16'd5);
        pin_a = 1'b1; step(4);
        chk("R5 rising ignored", cnt_q, 5);
        pin_a = 1'b0; step(4);
        chk("R5 falling counted", cnt_q, 4);

        // R8 pin B interrupt gate
        cur_req = "R8";
        edge_pos = 1'b1; clear_both();
        pulse_b();
        chk("R8 disabled", pend_b, 0);
        b_int_en = 1'b1; pulse_b();
        chk("R8 enabled", pend_b, 1);

        // R9 clear and set-wins
        cur_req = "R9";
        clear_both(); step(1);
        chk("R9 cleared", pend_b, 0);
        clr_b = 1'b1; pulse_b(); clr_b = 1'b0;
        chk("R9 clear held", pend_b, 0);

        // R6 capture wrap
        cur_req = "R6";
        mode_sel = 3'b100; step(2);
        wr(2'd0, 16'd1);
        chk("R6 loaded", cnt_q, 1);
        step(2);
        chk("R6 wrap", cnt_q, 16'hFFFF);

        // R7 captures
        cur_req = "R7";
        clear_both();
        pulse_a(); pulse_b();
        chk("R7 pend_a", pend_a, 1); chk("R7 pend_b", pend_b, 1);
        chk("R7 reg_a", reg_a_q, m_ra); chk("R7 reg_b", reg_b_q, m_rb);

        // R10 latency
        cur_req = "R10";
        clear_both(); step(2);
        pin_a = 1'b1;
        step(2);
        chk("R10 not yet", pend_a, 0);
        step(1);
        chk("R10 at third edge", pend_a, 1);
        pin_a = 1'b0; step(4);

        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule